// File: doc/BRIEF.md
# Byte-Wide External FIFO Streaming Port

This block moves a packet of bytes between a DMA engine and an external byte-wide FIFO chip. In the inbound direction it pulls bytes out of the FIFO with an active-low read strobe and hands each one to the DMA engine. In the outbound direction it takes bytes from the DMA engine and pushes them into the FIFO with an active-low write strobe. The DMA side uses a single request line, an acknowledge line and a direction flag. Each byte is one request and one acknowledge.

A transfer starts with a one-cycle start pulse for one direction, together with a byte count. Every strobe is low for a fixed number of clocks and then high for at least a fixed number of clocks. Both counts are parameters, chosen so that the FIFO's minimum cycle and minimum high time are met at the system clock rate. The strobe is never lowered while the FIFO reports empty (on reads) or full (on writes). While it waits, it stays high. When the count runs out, the block raises a one-cycle packet-end pulse and goes back to idle.

A request to clear the FIFO flags is passed on only between packets. A request made during a packet is refused and reported.

Top module: `fifo_stream_port`

## Requirements
- R1: After reset, both strobes (`fifoRdN`, `fifoWrN`) are high, and `dmaReq`, `pktEnd`, `flagClr` and `flagErr` are 0.
- R2: Each strobe pulse stays low for exactly CYC_CLKS-HIGH_CLKS clocks (6 by default). Before every falling edge the strobe has been high for at least HIGH_CLKS clocks (2). So one strobe cycle is never shorter than CYC_CLKS clocks (8).
- R3: During an outbound write, `fifoDout` does not change while `fifoWrN` is low, nor in the clock after it rises.
- R4: `fifoRdN` falls only if `fifoEmpty` was 0 in the previous clock. `fifoWrN` falls only if `fifoFull` was 0 in the previous clock.
- R5: Inbound (`startRd`): the byte on `fifoDin` in the last low clock of the read strobe goes to the DMA engine on `dmaRdData`, with `dmaReq`=1 and `dmaToMem`=1. These hold until `dmaAck` is seen. Bytes reach the DMA engine in FIFO order.
- R6: Outbound (`startWr`): `dmaReq`=1 with `dmaToMem`=0 asks for a byte. The byte on `dmaWrData` in the clock where `dmaAck`=1 is written to the FIFO. Bytes reach the FIFO in DMA order.
- R7: A transfer makes exactly `xferLen` strobe pulses and then exactly one `pktEnd` pulse of one clock. With `xferLen`=0, `pktEnd` pulses with no strobe at all.
- R8: When the empty or full flag blocks a transfer partway through, the strobe stays high for as long as the flag is set. No byte is dropped or repeated when the transfer resumes.
- R9: A `flagClrReq` sampled while idle makes `flagClr` high for one clock, in the following clock. A request sampled during a transfer makes `flagErr` high for one clock instead, and `flagClr` stays 0.
- R10: Start pulses that arrive during a transfer are ignored. They change neither its direction nor its length.
- R11: If `startRd` and `startWr` are both high in the same idle clock, the inbound direction wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| startRd | input | 1 | Start an inbound transfer (FIFO to DMA) |
| startWr | input | 1 | Start an outbound transfer (DMA to FIFO) |
| xferLen | input | LEN_W | Byte count, sampled with the start pulse |
| flagClrReq | input | 1 | Request to clear the FIFO flags |
| fifoDin | input | DATA_W | Byte bus from the FIFO |
| fifoEmpty | input | 1 | FIFO has no data |
| fifoFull | input | 1 | FIFO has no room |
| fifoRdN | output | 1 | Active-low read strobe |
| fifoWrN | output | 1 | Active-low write strobe |
| fifoDout | output | DATA_W | Byte bus to the FIFO |
| flagClr | output | 1 | Accepted flag clear, one clock |
| flagErr | output | 1 | Refused flag clear, one clock |
| dmaReq | output | 1 | Byte request to the DMA engine |
| dmaAck | input | 1 | DMA engine accepts the request |
| dmaToMem | output | 1 | 1: byte goes to memory; 0: byte is wanted from memory |
| dmaRdData | output | DATA_W | Byte delivered to the DMA engine |
| dmaWrData | input | DATA_W | Byte supplied by the DMA engine |
| pktEnd | output | 1 | Transfer complete, one clock |

## Verification
A length counter that decrements wrongly shows up as a strobe count different from the programmed length, or as a missing or doubled packet-end pulse, at the end of the packet. A phase counter with a wrong limit changes the width of the very first strobe pulse. A wrong direction or a wrong capture point shows up as a byte mismatch when the data stream is compared in the same packet. The sweeps run every short length against several acknowledge latencies, both with and without flag stalls. This means any corruption that appears only when a stall lands between two bytes also shows up as a stream mismatch within that packet.

// File: rtl/fifo_stream_pkg.sv
package fifo_stream_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FETCH,
    ST_WAIT,
    ST_LOW,
    ST_HIGH,
    ST_GIVE,
    ST_DONE
  } fs_state_t;

  typedef struct packed {
    logic loadLen;
    logic decLen;
    logic takeDma;
    logic takeFifo;
    logic clrPhase;
    logic incPhase;
  } fs_ctl_t;

endpackage

// File: rtl/fifo_stream_dp.sv
module fifo_stream_dp
  import fifo_stream_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int LEN_W  = 8,
  parameter int PH_W   = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  fs_ctl_t           ctl,
  input  logic [LEN_W-1:0]  xferLen,
  input  logic [DATA_W-1:0] fifoDin,
  input  logic [DATA_W-1:0] dmaWrData,
  output logic [DATA_W-1:0] dataOut,
  output logic              lenZero,
  output logic [PH_W-1:0]   phase
);

  logic [LEN_W-1:0]  lenCnt;
  logic [DATA_W-1:0] dataReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lenCnt <= '0;
    end else if (ctl.loadLen) begin
      lenCnt <= xferLen;
    end else if (ctl.decLen) begin
      lenCnt <= lenCnt - LEN_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dataReg <= '0;
    end else if (ctl.takeDma) begin
      dataReg <= dmaWrData;
    end else if (ctl.takeFifo) begin
      dataReg <= fifoDin;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase <= '0;
    end else if (ctl.clrPhase) begin
      phase <= '0;
    end else if (ctl.incPhase) begin
      phase <= phase + PH_W'(1);
    end
  end

  assign dataOut = dataReg;
  assign lenZero = (lenCnt == '0);

endmodule

// File: rtl/fifo_stream_ctrl.sv
module fifo_stream_ctrl
  import fifo_stream_pkg::*;
#(
  parameter int LEN_W     = 8,
  parameter int PH_W      = 3,
  parameter int LOW_CLKS  = 6,
  parameter int HIGH_CLKS = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             startRd,
  input  logic             startWr,
  input  logic [LEN_W-1:0] xferLen,
  input  logic             flagClrReq,
  input  logic             fifoEmpty,
  input  logic             fifoFull,
  input  logic             dmaAck,
  input  logic             lenZero,
  input  logic [PH_W-1:0]  phase,
  output fs_ctl_t          ctl,
  output logic             rdStrobeN,
  output logic             wrStrobeN,
  output logic             dmaReq,
  output logic             dmaToMem,
  output logic             pktEnd,
  output logic             flagClr,
  output logic             flagErr
);

  localparam logic [PH_W-1:0] LOW_LAST  = PH_W'(LOW_CLKS - 1);
  localparam logic [PH_W-1:0] HIGH_LAST = PH_W'(HIGH_CLKS - 1);

  fs_state_t state, stateNext;
  logic      dirRd, dirRdNext;
  logic      blocked;

  assign blocked = dirRd ? fifoEmpty : fifoFull;

  always_comb begin
    stateNext = state;
    dirRdNext = dirRd;
    ctl       = '0;
    unique case (state)
      ST_IDLE: begin
        if (startRd || startWr) begin
          dirRdNext = startRd;
          if (xferLen == '0) begin
            stateNext = ST_DONE;
          end else begin
            ctl.loadLen = 1'b1;
            stateNext   = startRd ? ST_WAIT : ST_FETCH;
          end
        end
      end
      ST_FETCH: begin
        if (dmaAck) begin
          ctl.takeDma = 1'b1;
          stateNext   = ST_WAIT;
        end
      end
      ST_WAIT: begin
        if (!blocked) begin
          ctl.clrPhase = 1'b1;
          stateNext    = ST_LOW;
        end
      end
      ST_LOW: begin
        if (phase == LOW_LAST) begin
          ctl.clrPhase = 1'b1;
          ctl.decLen   = 1'b1;
          ctl.takeFifo = dirRd;
          stateNext    = ST_HIGH;
        end else begin
          ctl.incPhase = 1'b1;
        end
      end
      ST_HIGH: begin
        if (phase == HIGH_LAST) begin
          if (dirRd)        stateNext = ST_GIVE;
          else if (lenZero) stateNext = ST_DONE;
          else              stateNext = ST_FETCH;
        end else begin
          ctl.incPhase = 1'b1;
        end
      end
      ST_GIVE: begin
        if (dmaAck) stateNext = lenZero ? ST_DONE : ST_WAIT;
      end
      ST_DONE:  stateNext = ST_IDLE;
      default:  stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      dirRd   <= 1'b0;
      flagClr <= 1'b0;
      flagErr <= 1'b0;
    end else begin
      state   <= stateNext;
      dirRd   <= dirRdNext;
      flagClr <= flagClrReq && (state == ST_IDLE);
      flagErr <= flagClrReq && (state != ST_IDLE);
    end
  end

  assign rdStrobeN = !((state == ST_LOW) && dirRd);
  assign wrStrobeN = !((state == ST_LOW) && !dirRd);
  assign dmaReq    = (state == ST_FETCH) || (state == ST_GIVE);
  assign dmaToMem  = dirRd;
  assign pktEnd    = (state == ST_DONE);

endmodule

// File: rtl/fifo_stream_port.sv
module fifo_stream_port
  import fifo_stream_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int LEN_W     = 8,
  parameter int CYC_CLKS  = 8,
  parameter int HIGH_CLKS = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              startRd,
  input  logic              startWr,
  input  logic [LEN_W-1:0]  xferLen,
  input  logic              flagClrReq,
  input  logic [DATA_W-1:0] fifoDin,
  input  logic              fifoEmpty,
  input  logic              fifoFull,
  output logic              fifoRdN,
  output logic              fifoWrN,
  output logic [DATA_W-1:0] fifoDout,
  output logic              flagClr,
  output logic              flagErr,
  output logic              dmaReq,
  input  logic              dmaAck,
  output logic              dmaToMem,
  output logic [DATA_W-1:0] dmaRdData,
  input  logic [DATA_W-1:0] dmaWrData,
  output logic              pktEnd
);

  localparam int LOW_CLKS = CYC_CLKS - HIGH_CLKS;
  localparam int PH_W     = (CYC_CLKS > 2) ? $clog2(CYC_CLKS) : 1;

  fs_ctl_t           ctl;
  logic              lenZero;
  logic [PH_W-1:0]   phase;
  logic [DATA_W-1:0] dataOut;

  fifo_stream_ctrl #(
    .LEN_W(LEN_W), .PH_W(PH_W), .LOW_CLKS(LOW_CLKS), .HIGH_CLKS(HIGH_CLKS)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .startRd(startRd), .startWr(startWr),
    .xferLen(xferLen), .flagClrReq(flagClrReq), .fifoEmpty(fifoEmpty),
    .fifoFull(fifoFull), .dmaAck(dmaAck), .lenZero(lenZero), .phase(phase),
    .ctl(ctl), .rdStrobeN(fifoRdN), .wrStrobeN(fifoWrN), .dmaReq(dmaReq),
    .dmaToMem(dmaToMem), .pktEnd(pktEnd), .flagClr(flagClr), .flagErr(flagErr)
  );

  fifo_stream_dp #(
    .DATA_W(DATA_W), .LEN_W(LEN_W), .PH_W(PH_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .xferLen(xferLen), .fifoDin(fifoDin),
    .dmaWrData(dmaWrData), .dataOut(dataOut), .lenZero(lenZero), .phase(phase)
  );

  assign fifoDout  = dataOut;
  assign dmaRdData = dataOut;

endmodule

// File: rtl/fifo_stream_chk.sv
module fifo_stream_chk #(
  parameter int DATA_W    = 8,
  parameter int CYC_CLKS  = 8,
  parameter int HIGH_CLKS = 2
) (
  input logic              clk,
  input logic              rstN,
  input logic              fifoRdN,
  input logic              fifoWrN,
  input logic              fifoEmpty,
  input logic              fifoFull,
  input logic [DATA_W-1:0] fifoDout,
  input logic              dmaReq,
  input logic              dmaAck,
  input logic              dmaToMem,
  input logic              pktEnd,
  input logic              flagClr,
  input logic              flagErr
);

  localparam int LOW_CLKS = CYC_CLKS - HIGH_CLKS;

  logic       strobeN;
  logic [7:0] lowCnt;
  logic [7:0] highCnt;

  assign strobeN = fifoRdN && fifoWrN;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lowCnt  <= '0;
      highCnt <= 8'(HIGH_CLKS);
    end else begin
      lowCnt  <= strobeN ? 8'd0 : lowCnt + 8'd1;
      highCnt <= !strobeN ? 8'd0 : (highCnt == 8'hFF ? highCnt : highCnt + 8'd1);
    end
  end

  p_low_width_r2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(strobeN) |-> lowCnt == 8'(LOW_CLKS));

  p_high_width_r2: assert property (@(posedge clk) disable iff (!rstN)
    $fell(strobeN) |-> highCnt >= 8'(HIGH_CLKS));

  p_dout_stable_r3: assert property (@(posedge clk) disable iff (!rstN)
    !fifoWrN |=> $stable(fifoDout));

  p_rd_gate_r4: assert property (@(posedge clk) disable iff (!rstN)
    $fell(fifoRdN) |-> !$past(fifoEmpty));

  p_wr_gate_r4: assert property (@(posedge clk) disable iff (!rstN)
    $fell(fifoWrN) |-> !$past(fifoFull));

  p_req_hold_r5: assert property (@(posedge clk) disable iff (!rstN)
    (dmaReq && !dmaAck) |=> (dmaReq && $stable(dmaToMem)));

  p_pkt_pulse_r7: assert property (@(posedge clk) disable iff (!rstN)
    pktEnd |=> !pktEnd);

  p_one_strobe_r2: assert property (@(posedge clk) disable iff (!rstN)
    fifoRdN || fifoWrN);

  p_flag_excl_r9: assert property (@(posedge clk) disable iff (!rstN)
    !(flagClr && flagErr));

endmodule

bind fifo_stream_port fifo_stream_chk #(
  .DATA_W(DATA_W), .CYC_CLKS(CYC_CLKS), .HIGH_CLKS(HIGH_CLKS)
) u_chk (
  .clk(clk), .rstN(rstN), .fifoRdN(fifoRdN), .fifoWrN(fifoWrN),
  .fifoEmpty(fifoEmpty), .fifoFull(fifoFull), .fifoDout(fifoDout),
  .dmaReq(dmaReq), .dmaAck(dmaAck), .dmaToMem(dmaToMem), .pktEnd(pktEnd),
  .flagClr(flagClr), .flagErr(flagErr)
);

// File: tb/tb_fifo_stream_port.sv
module tb_fifo_stream_port;

  localparam int LOWC  = 6;
  localparam int HIGHC = 2;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       startRd = 1'b0, startWr = 1'b0, flagClrReq = 1'b0;
  logic [7:0] xferLen = '0;
  logic [7:0] fifoDin = '0;
  logic       fifoEmpty = 1'b0, fifoFull = 1'b0;
  logic       fifoRdN, fifoWrN, flagClr, flagErr, dmaReq, dmaToMem, pktEnd;
  logic [7:0] fifoDout, dmaRdData;
  logic       dmaAck = 1'b0;
  logic [7:0] dmaWrData = '0;

  always #4 clk = ~clk;

  fifo_stream_port dut (
    .clk(clk), .rstN(rstN), .startRd(startRd), .startWr(startWr),
    .xferLen(xferLen), .flagClrReq(flagClrReq), .fifoDin(fifoDin),
    .fifoEmpty(fifoEmpty), .fifoFull(fifoFull), .fifoRdN(fifoRdN),
    .fifoWrN(fifoWrN), .fifoDout(fifoDout), .flagClr(flagClr),
    .flagErr(flagErr), .dmaReq(dmaReq), .dmaAck(dmaAck), .dmaToMem(dmaToMem),
    .dmaRdData(dmaRdData), .dmaWrData(dmaWrData), .pktEnd(pktEnd)
  );

  int checks = 0, failures = 0;
  int seed = 0, ackLat = 0, stallOn = 0, forceBlock = 0;
  int rdFalls = 0, wrFalls = 0, wrRises = 0, dmaGot = 0, wrIdx = 0;
  int pktCnt = 0, widthErr = 0, gateErr = 0, blockHold = 0, ackWait = 0;
  int lowRun = 0, highRun = 100;
  logic prevRd = 1'b1, prevWr = 1'b1;
  logic [7:0] memLog [64];
  logic [7:0] fifoLog[64];

  function automatic logic [7:0] rdPat(int i);
    return 8'((i * 37 + 5 + seed) & 255);
  endfunction
  function automatic logic [7:0] wrPat(int i);
    return 8'((i * 91 + 3 + seed) & 255);
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic clearStats();
    rdFalls = 0; wrFalls = 0; wrRises = 0; dmaGot = 0; wrIdx = 0;
    pktCnt = 0; widthErr = 0; gateErr = 0;
  endtask

  // FIFO and DMA models, driving only at falling edges
  initial begin
    forever begin
      @(negedge clk);
      begin
        logic seenEmpty, seenFull, strobe, prevStrobe;
        seenEmpty = fifoEmpty; seenFull = fifoFull;
        strobe = fifoRdN & fifoWrN; prevStrobe = prevRd & prevWr;
        if (!strobe) begin
          if (prevStrobe) begin
            if (highRun < HIGHC) widthErr++;
            highRun = 0;
          end
          lowRun++;
        end else begin
          if (!prevStrobe) begin
            if (lowRun != LOWC) widthErr++;
            lowRun = 0;
          end
          if (highRun < 1000) highRun++;
        end
        if (prevRd && !fifoRdN) begin
          if (seenEmpty) gateErr++;
          fifoDin = rdPat(rdFalls);
          rdFalls++;
        end
        if (prevWr && !fifoWrN) begin
          if (seenFull) gateErr++;
          wrFalls++;
        end
        if (!prevWr && fifoWrN) begin
          if (wrRises < 64) fifoLog[wrRises] = fifoDout;
          wrRises++;
        end
        if (blockHold > 0) blockHold--;
        if (strobe && !prevStrobe && stallOn != 0) blockHold = 4;
        fifoEmpty = (forceBlock != 0) || (blockHold > 0);
        fifoFull  = (forceBlock != 0) || (blockHold > 0);
        if (pktEnd) pktCnt++;
        if (dmaAck) begin
          dmaAck = 1'b0;
        end else if (dmaReq) begin
          if (ackWait >= ackLat) begin
            ackWait = 0;
            dmaAck = 1'b1;
            if (dmaToMem) begin
              if (dmaGot < 64) memLog[dmaGot] = dmaRdData;
              dmaGot++;
            end else begin
              dmaWrData = wrPat(wrIdx);
              wrIdx++;
            end
          end else begin
            ackWait++;
          end
        end
        prevRd = fifoRdN; prevWr = fifoWrN;
      end
    end
  end

  task automatic pulseStart(input bit rd, input bit wr, input int len);
    @(negedge clk); #1;
    startRd = rd; startWr = wr; xferLen = 8'(len);
    @(negedge clk); #1;
    startRd = 1'b0; startWr = 1'b0;
  endtask

  task automatic waitPkt();
    for (int t = 0; t < 3000 && pktCnt == 0; t++) begin
      @(negedge clk); #1;
    end
    repeat (6) @(negedge clk);
    #1;
  endtask

  task automatic runXfer(input bit rd, input int len, input int lat, input int stall);
    int bad = 0, badAct = 0, badExp = 0;
    clearStats();
    ackLat = lat; stallOn = stall; seed = len * 7 + lat * 3 + stall;
    pulseStart(rd, !rd, len);
    waitPkt();
    if (rd) begin
      check(rdFalls == len && wrFalls == 0, "R7 read strobe count", rdFalls, len);
      check(dmaGot == len, "R5 bytes to dma", dmaGot, len);
      for (int i = 0; i < len; i++)
        if (bad == 0 && memLog[i] != rdPat(i)) begin
          bad = 1; badAct = memLog[i]; badExp = rdPat(i);
        end
      check(bad == 0, stall ? "R8 read stream after stall" : "R5 read stream", badAct, badExp);
    end else begin
      check(wrRises == len && rdFalls == 0, "R7 write strobe count", wrRises, len);
      for (int i = 0; i < len; i++)
        if (bad == 0 && fifoLog[i] != wrPat(i)) begin
          bad = 1; badAct = fifoLog[i]; badExp = wrPat(i);
        end
      check(bad == 0, stall ? "R8 write stream after stall" : "R6 write stream", badAct, badExp);
    end
    check(pktCnt == 1, "R7 single pktEnd", pktCnt, 1);
    check(widthErr == 0, "R2 strobe widths", widthErr, 0);
    check(gateErr == 0, "R4 flag gating", gateErr, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #1;
    check(fifoRdN && fifoWrN, "R1 strobes high in reset", {fifoRdN, fifoWrN}, 3);
    rstN = 1'b1;
    @(negedge clk); #1;
    check(!dmaReq && !pktEnd && !flagClr && !flagErr, "R1 idle outputs",
          {dmaReq, pktEnd, flagClr, flagErr}, 0);

    for (int rd = 0; rd < 2; rd++)
      for (int len = 1; len <= 6; len++)
        for (int lat = 0; lat < 3; lat++)
          for (int st = 0; st < 2; st++)
            runXfer(rd[0], len, lat, st);

    // R7 zero length
    clearStats();
    pulseStart(1'b1, 1'b0, 0);
    waitPkt();
    check(pktCnt == 1 && rdFalls == 0 && wrFalls == 0, "R7 zero length",
          pktCnt * 100 + rdFalls + wrFalls, 100);

    // R8 blocked before first byte; R9 refusal while busy
    clearStats();
    ackLat = 0; stallOn = 0; seed = 11;
    forceBlock = 1;
    @(negedge clk); #1;
    pulseStart(1'b1, 1'b0, 3);
    repeat (40) @(negedge clk);
    #1;
    check(rdFalls == 0 && fifoRdN, "R8 strobe held while empty", rdFalls, 0);
    flagClrReq = 1'b1;
    @(negedge clk); #1;
    flagClrReq = 1'b0;
    check(flagErr && !flagClr, "R9 refuse clear while busy", {flagErr, flagClr}, 2);
    @(negedge clk); #1;
    check(!flagErr, "R9 error pulse one clock", flagErr, 0);
    forceBlock = 0;
    waitPkt();
    check(rdFalls == 3 && dmaGot == 3 && memLog[2] == rdPat(2), "R8 resume after block",
          dmaGot, 3);

    // R9 accepted while idle
    flagClrReq = 1'b1;
    @(negedge clk); #1;
    flagClrReq = 1'b0;
    check(flagClr && !flagErr, "R9 clear accepted when idle", {flagClr, flagErr}, 2);
    @(negedge clk); #1;
    check(!flagClr, "R9 clear pulse one clock", flagClr, 0);

    // R10 start during transfer ignored
    clearStats();
    ackLat = 2; seed = 21;
    pulseStart(1'b1, 1'b0, 3);
    repeat (10) @(negedge clk);
    pulseStart(1'b0, 1'b1, 9);
    waitPkt();
    repeat (20) @(negedge clk);
    #1;
    check(rdFalls == 3 && wrFalls == 0 && pktCnt == 1, "R10 start ignored when busy",
          rdFalls * 10 + wrFalls, 30);

    // R11 simultaneous start
    clearStats();
    ackLat = 0; seed = 33;
    pulseStart(1'b1, 1'b1, 2);
    waitPkt();
    check(rdFalls == 2 && wrFalls == 0, "R11 read wins tie", rdFalls * 10 + wrFalls, 20);

    // R3 data held across write strobe checked by value after a slow-ack burst
    runXfer(1'b0, 8, 1, 1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule